// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host read and write an external asynchronous static RAM that stores 16-bit words and has a separate active-low enable for each byte lane. The host offers a request through a ready/valid handshake. Each request carries a direction, a word address, write data and an active-high byte mask. The controller then runs a fixed sequence of SETUP, ACCESS and DONE cycles on the memory pins. It returns read data together with a one-cycle done pulse.

On the memory side it drives the address, an active-low chip select, write strobe, output enable, one active-low enable per byte lane, and a shared bidirectional data bus. The controller drives the bus only during a write, and it keeps the address and chip select steady for one cycle after the write strobe rises. The number of ACCESS cycles comes from the clock period and the memory's read access time, both of which are parameters. Every memory-side output comes from a register.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, write strobe and output enable are high. Both lane enables are high (2'b11), the controller does not drive the data bus, ready is high and done is low.
- R2: A write with a nonzero mask drives chip select and write strobe low, with output enable high and the data bus driven. The lane enables are the bitwise inverse of the mask: mask bit 0 selects data bits 7:0 and mask bit 1 selects data bits 15:8. Only the selected lanes of the addressed word change.
- R3: A read with a nonzero mask drives chip select and output enable low with the write strobe high. The returned data carries the memory value in the enabled lanes and zero in the lanes the mask leaves out.
- R4: The controller drives the data bus only while output enable is high and chip select is low. It never drives the bus during a read or while idle.
- R5: After the write strobe rises, the address, chip select and the driven bus stay unchanged for one more cycle before the bus is released and chip select rises.
- R6: A request with mask 2'b00 takes no memory action: chip select stays high. Done appears in the first cycle after the request is accepted.
- R7: For a nonzero mask, done appears exactly 2 + W cycles after the accepting edge, where W = max(1, ceil(TAA_PS / CLK_PS)). Read data is sampled at the end of the W-th ACCESS cycle.
- R8: Done lasts exactly one cycle per request. Ready is high only when the controller is idle, so no request is accepted while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Active-high byte mask (bit 0 = bits 7:0) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_addr | output | ADDR_W (16) | Memory word address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low lane enables (bit 0 = bits 7:0) |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
Each request is driven on a falling edge. The bench then counts falling edges until done is seen. Done must appear on the first of them for a mask of 2'b00 and on the (2 + W)-th otherwise, with W = 2 for an 8 ns clock and a 12 ns access. Read data is checked on the same falling edge as done, because the value is captured at the end of ACCESS and held through DONE. Pin sequencing is checked on falling edges between the accepting edge and done: lane enables during the strobe, chip select during no-ops, and address and chip select in the cycle after the write strobe rises.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } lane_st_e;

  function automatic int unsigned wait_cycles(input int unsigned clk_ps, input int unsigned taa_ps);
    int unsigned w;
    w = (taa_ps + clk_ps - 1) / clk_ps;
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer
  import sram_lane_pkg::*;
#(
  parameter int unsigned WAIT = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  lane_st_e st_q,
  output logic     wait_last
);
  localparam int unsigned CNT_W = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || st_q != ST_ACCESS) cnt_q <= '0;
    else if (cnt_q != LAST)       cnt_q <= cnt_q + 1'b1;
  end

  assign wait_last = (st_q == ST_ACCESS) && (cnt_q == LAST);

  p_wait_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_ACCESS) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LANES-1:0] req_mask,
  input  logic             wait_last,
  output lane_st_e         st_q,
  output lane_st_e         st_nxt
);
  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_nxt = (req_mask == '0) ? ST_DONE : ST_SETUP;
      ST_SETUP:  st_nxt = ST_ACCESS;
      ST_ACCESS: if (wait_last) st_nxt = ST_DONE;
      ST_DONE:   st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_nxt;
  end

  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));
  p_setup_then_access_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETUP) |=> (st_q == ST_ACCESS));
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_st_e          st_q,
  input  lane_st_e          st_nxt,
  input  logic              wait_last,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              dq_drive,
  output logic [DATA_W-1:0] dq_out
);
  localparam int unsigned LANE_W = DATA_W / LANES;

  logic              accept;
  logic              wr_q, wr_f;
  logic [ADDR_W-1:0] addr_q, addr_f;
  logic [DATA_W-1:0] wdata_q, wdata_f;
  logic [LANES-1:0]  mask_q, mask_f;
  logic [DATA_W-1:0] lane_bits;

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign wr_f    = accept ? req_write : wr_q;
  assign addr_f  = accept ? req_addr  : addr_q;
  assign wdata_f = accept ? req_wdata : wdata_q;
  assign mask_f  = accept ? req_mask  : mask_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[l*LANE_W +: LANE_W] = {LANE_W{mask_q[l]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      wr_q    <= wr_f;
      addr_q  <= addr_f;
      wdata_q <= wdata_f;
      mask_q  <= mask_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      dq_drive  <= 1'b0;
      dq_out    <= '0;
    end else begin
      req_ready <= (st_nxt == ST_IDLE);
      rsp_done  <= (st_nxt == ST_DONE);
      mem_addr  <= addr_f;
      dq_out    <= wdata_f;
      if (wait_last && !wr_q) rsp_rdata <= dq_in & lane_bits;
      else if (accept)        rsp_rdata <= '0;
      unique case (st_nxt)
        ST_SETUP: begin
          mem_ce_n <= 1'b0;
          mem_we_n <= 1'b1;
          mem_oe_n <= wr_f;
          mem_be_n <= ~mask_f;
          dq_drive <= 1'b0;
        end
        ST_ACCESS: begin
          mem_ce_n <= 1'b0;
          mem_we_n <= ~wr_f;
          mem_oe_n <= wr_f;
          mem_be_n <= ~mask_f;
          dq_drive <= wr_f;
        end
        ST_DONE: begin
          mem_ce_n <= ~(wr_f && mask_f != '0);
          mem_we_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_be_n <= (wr_f && mask_f != '0) ? ~mask_f : '1;
          dq_drive <= wr_f && mask_f != '0;
        end
        default: begin
          mem_ce_n <= 1'b1;
          mem_we_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_be_n <= '1;
          dq_drive <= 1'b0;
        end
      endcase
    end
  end

  p_drive_oe_high_r4: assert property (@(posedge clk) disable iff (rst)
    dq_drive |-> (mem_oe_n && !mem_ce_n));
  p_strobe_ce_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && dq_drive));
  p_read_strobe_high_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !dq_drive));
  p_we_rise_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && dq_drive && $stable(mem_addr)));
  p_release_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_drive) |-> $past(mem_we_n));
  p_ce_needs_lane_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> (mem_be_n != '1));
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !dq_drive));
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CLK_PS = 8000,
  parameter int unsigned TAA_PS = 12000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [1:0]        mem_be_n,
  inout  wire  [15:0]       mem_dq
);
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned WAIT   = wait_cycles(CLK_PS, TAA_PS);

  lane_st_e          st_q, st_nxt;
  logic              wait_last;
  logic              dq_drive;
  logic [DATA_W-1:0] dq_out;

  assign mem_dq = dq_drive ? dq_out : {DATA_W{1'bz}};

  sram_lane_fsm #(.LANES(LANES)) u_fsm (
    .clk, .rst, .req_valid, .req_mask, .wait_last, .st_q, .st_nxt
  );

  sram_lane_timer #(.WAIT(WAIT)) u_timer (
    .clk, .rst, .st_q, .wait_last
  );

  sram_lane_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk, .rst, .st_q, .st_nxt, .wait_last,
    .req_valid, .req_write, .req_addr, .req_wdata, .req_mask,
    .dq_in(mem_dq),
    .req_ready, .rsp_done, .rsp_rdata,
    .mem_addr, .mem_ce_n, .mem_we_n, .mem_oe_n, .mem_be_n,
    .dq_drive, .dq_out
  );
endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;
  localparam int unsigned AW   = 8;
  localparam int unsigned WAIT = 2;   // ceil(12000/8000)
  localparam int unsigned NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rsp_done;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]    mem_be_n;
  wire  [15:0]   mem_dq;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NW];
  logic [15:0] shadow [NW];

  always #4 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(AW), .CLK_PS(8000), .TAA_PS(12000)) u_dut (
    .clk, .rst, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .req_mask, .rsp_done, .rsp_rdata, .mem_addr, .mem_ce_n, .mem_we_n,
    .mem_oe_n, .mem_be_n, .mem_dq
  );

  // memory model
  wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (rd_on && !mem_be_n[0]) ? model[mem_addr][7:0]  : 8'hzz;
  assign mem_dq[15:8] = (rd_on && !mem_be_n[1]) ? model[mem_addr][15:8] : 8'hzz;
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_be_n[0]) model[mem_addr][7:0]  <= mem_dq[7:0];
      if (!mem_be_n[1]) model[mem_addr][15:8] <= mem_dq[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5: the cycle after the strobe rises keeps address and chip select
  logic          pv_we = 1'b1;
  logic [AW-1:0] pv_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!pv_we && mem_we_n) begin
        chk(!mem_ce_n, "R5 ce held after strobe", {31'd0, mem_ce_n}, 32'd0);
        chk(mem_addr == pv_addr, "R5 addr held after strobe", {24'd0, mem_addr}, {24'd0, pv_addr});
      end
      pv_we   <= mem_we_n;
      pv_addr <= mem_addr;
    end
  end

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'((a * 16'h0137) ^ (k * 16'h5A3C) ^ 16'hC3E1);
  endfunction

  task automatic access(input bit wr, input int a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd);
    int lat = 0;
    int exp_lat;
    bit saw_strobe = 0, saw_oe = 0, ce_seen = 0, busy_ready = 0;
    logic [1:0] be_seen = 2'b11;
    exp_lat = (m == 2'b00) ? 1 : 2 + WAIT;
    chk(req_ready, "R8 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (!mem_ce_n) ce_seen = 1;
      if (!mem_we_n) begin saw_strobe = 1; be_seen = mem_be_n; end
      if (!mem_oe_n) begin
        saw_oe = 1; be_seen = mem_be_n;
        if (!mem_we_n) saw_strobe = 1;
      end
      if (rsp_done || lat > 40) break;
      if (req_ready) busy_ready = 1;
    end
    rd = rsp_rdata;
    chk(lat == exp_lat, m == 2'b00 ? "R6 noop latency" : "R7 done latency", lat, exp_lat);
    chk(!busy_ready, "R8 ready low while busy", {31'd0, busy_ready}, 32'd0);
    @(negedge clk);
    chk(!rsp_done, "R8 done one cycle", {31'd0, rsp_done}, 32'd0);
    if (m == 2'b00) begin
      chk(!ce_seen, "R6 noop keeps ce high", {31'd0, ce_seen}, 32'd0);
    end else if (wr) begin
      chk(saw_strobe && !saw_oe && be_seen == ~m, "R2 strobe with lane enables",
          {30'd0, be_seen}, {30'd0, ~m});
    end else begin
      chk(saw_oe && !saw_strobe && be_seen == ~m, "R3 output enable with strobe high",
          {30'd0, be_seen}, {30'd0, ~m});
    end
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] exp;
    for (int i = 0; i < NW; i++) begin model[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
        {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'd7);
    chk(mem_be_n == 2'b11, "R1 lanes disabled in reset", {30'd0, mem_be_n}, 32'd3);
    chk(req_ready && !rsp_done, "R1 ready high, done low", {30'd0, req_ready, rsp_done}, 32'd2);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && req_ready, "R1 idle after reset",
        {29'd0, mem_ce_n, mem_oe_n, req_ready}, 32'd7);

    // full-word writes over every address, then read back (R2, R3, R4)
    for (int a = 0; a < NW; a++) begin
      access(1'b1, a, pat(a, 0), 2'b11, rd);
      shadow[a] = pat(a, 0);
    end
    for (int a = 0; a < NW; a++) begin
      access(1'b0, a, 16'h0, 2'b11, rd);
      chk(rd == shadow[a], "R4 read with bus released", rd, shadow[a]);
    end

    // lane writes and lane reads
    for (int a = 0; a < 32; a++) begin
      for (int m = 1; m < 3; m++) begin
        logic [15:0] lm;
        lm = (m == 1) ? 16'h00FF : 16'hFF00;
        access(1'b1, a, pat(a, m), 2'(m), rd);
        shadow[a] = (shadow[a] & ~lm) | (pat(a, m) & lm);
        access(1'b0, a, 16'h0, 2'b11, rd);
        chk(rd == shadow[a], "R2 only selected lane written", rd, shadow[a]);
        for (int r = 1; r < 3; r++) begin
          exp = shadow[a] & ((r == 1) ? 16'h00FF : 16'hFF00);
          access(1'b0, a, 16'h0, 2'(r), rd);
          chk(rd == exp, "R3 disabled lane reads zero", rd, exp);
        end
      end
    end

    // no-op requests of both kinds leave memory unchanged
    for (int a = 0; a < 16; a++) begin
      access(1'b1, a, ~shadow[a], 2'b00, rd);
      access(1'b0, a, 16'h0, 2'b00, rd);
      chk(rd == 16'h0, "R6 noop read returns zero", rd, 16'h0);
      access(1'b0, a, 16'h0, 2'b11, rd);
      chk(rd == shadow[a], "R6 noop write leaves word", rd, shadow[a]);
    end

    // back-to-back write then read at the same address
    access(1'b1, 7, 16'hBEEF, 2'b11, rd);
    access(1'b0, 7, 16'h0, 2'b11, rd);
    chk(rd == 16'hBEEF, "R7 read after write", rd, 16'hBEEF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule